// File: doc/BRIEF.md
# Debug Instruction Injection Port

This block is a debug port, reached through a standard four-wire test access port, that lets an external debugger push opcodes and data words into a halted processor core. A 16-state TAP controller steps through its states on TMS. A 5-bit instruction register selects which data chain sits between TDI and TDO. For the debug instructions, a stored chain number, loaded with a chain-select instruction, picks between an instruction-transfer chain, a data-transfer chain and a debug control chain. A dedicated shortcut instruction reaches the instruction-transfer chain without rewriting the stored chain number.

The core sees a small interface. An issue strobe comes with the opcode to execute, and a done pulse comes back. For data in the debugger-to-core direction there is a write strobe with its word. For the core-to-debugger direction, the core offers a word with a valid flag and receives a take pulse. Execution is tied to the TAP walk. Entering Run-Test/Idle launches the held opcode, but only when the instruction-transfer Ready flag is set, execution is enabled in the control chain, the core is halted, and the instruction register together with the chain number arms execution.

Top module: `dbg_inject_port`

## Requirements
- R1: Reset, and every pass through Test-Logic-Reset, load the bypass instruction 5'h1F. Bypass is a 1-bit chain that captures 0 and delays TDI by one TCK. After reset Ready is 1, execution is disabled, the stored chain number is 0 and no issue strobe is raised. All chains shift LSB first.
- R2: Instruction 5'h02 selects the 5-bit chain-number chain. Capture-DR loads the current chain number into it. The shifted number is stored only on passing Update-DR.
- R3: Instruction 5'h1D routes DR scans to the instruction-transfer chain and leaves the stored chain number unchanged.
- R4: The instruction-transfer chain is 33 bits long. Bit 0 captures Ready and bits 32:1 capture 0. Bits 32:1 form the opcode written on Update-DR.
- R5: An opcode shifted while Ready is 0 is discarded on Update-DR. The previously held opcode is the one issued next.
- R6: Entering Run-Test/Idle raises core_issue for one cycle, with the held opcode on core_opcode, only if all of the following hold: Ready is 1, the execution-enable bit is 1, core_halted is 1, and the instruction is 5'h1D, or it is 5'h0C or 5'h00 with chain number 4 or 5.
- R7: Remaining in Run-Test/Idle for many cycles produces exactly one issue. Another issue needs the TAP to leave Idle and enter it again.
- R8: With chain number 1, or an unassigned chain number such as 2, selected under 5'h0C or 5'h00, entering Idle issues nothing. An unassigned chain number, or an unknown instruction, acts as the 1-bit bypass chain.
- R9: Chain number 1 is a 32-bit control chain. Capture places Ready in bit 2, core_halted in bit 1 and execution-enable in bit 0. Under 5'h00, Update-DR writes execution-enable from bit 0. Under 5'h0C nothing is written.
- R10: Chain number 5 is a 33-bit data-transfer chain that captures core_dtr_valid in bit 0 and core_dtr_data in bits 32:1. A capture under 5'h0C while core_dtr_valid is 1 pulses core_dtr_take once.
- R11: Under 5'h00 on chain number 5, Update-DR pulses dtr_wr_strobe for one cycle with bits 32:1 on dtr_wr_data. Under 5'h0C no write strobe occurs.
- R12: Any instruction code other than 5'h00, 5'h02, 5'h0C and 5'h1D selects the 1-bit bypass chain.
- R13: Ready clears in the same cycle an issue is raised and sets again on core_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock (TCK); all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the active shift register in Shift states, else 0 |
| core_halted | input | 1 | Core is halted in debug state |
| core_done | input | 1 | Core finished the last issued opcode (one-cycle pulse) |
| core_dtr_data | input | DATA_W | Word offered by the core to the debugger |
| core_dtr_valid | input | 1 | core_dtr_data holds an unread word |
| core_issue | output | 1 | One-cycle execute strobe |
| core_opcode | output | DATA_W | Opcode held for execution |
| core_dtr_take | output | 1 | Debugger consumed the offered word |
| dtr_wr_strobe | output | 1 | Debugger word ready for the core |
| dtr_wr_data | output | DATA_W | Debugger word for the core |

## Verification
The hardest case to reach is an instruction-transfer scan that lands while Ready is low. Ready only drops after a real issue, and the bench holds back core_done at that point, so the write reaching Update-DR has to be dropped. The bench then releases done and re-enters Idle by reloading the shortcut instruction. The issued opcode shows whether the dropped write leaked in. A long Idle dwell directly after an issue covers the single-execution rule. Random opcodes then run with an automatic done responder, each scan followed by a random Idle length.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;

    localparam int IR_W  = 5;
    localparam int SEL_W = 5;

    localparam logic [IR_W-1:0] OP_EXTEST  = 5'h00;
    localparam logic [IR_W-1:0] OP_CHSEL   = 5'h02;
    localparam logic [IR_W-1:0] OP_INTEST  = 5'h0C;
    localparam logic [IR_W-1:0] OP_ITRPICK = 5'h1D;
    localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;

    localparam logic [SEL_W-1:0] CH_CTRL_NUM = 5'd1;
    localparam logic [SEL_W-1:0] CH_ITR_NUM  = 5'd4;
    localparam logic [SEL_W-1:0] CH_DTR_NUM  = 5'd5;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_DR_SEL, TS_DR_CAP, TS_DR_SHIFT, TS_DR_EX1, TS_DR_PAUSE, TS_DR_EX2, TS_DR_UPD,
        TS_IR_SEL, TS_IR_CAP, TS_IR_SHIFT, TS_IR_EX1, TS_IR_PAUSE, TS_IR_EX2, TS_IR_UPD
    } tap_state_e;

    typedef enum logic [2:0] {RT_BYPASS, RT_SEL, RT_ITR, RT_DTR, RT_CTRL} route_e;

    function automatic tap_state_e tap_step(tap_state_e s, logic m);
        case (s)
            TS_RESET:    return m ? TS_RESET    : TS_IDLE;
            TS_IDLE:     return m ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   return m ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   return m ? TS_DR_EX1   : TS_DR_SHIFT;
            TS_DR_SHIFT: return m ? TS_DR_EX1   : TS_DR_SHIFT;
            TS_DR_EX1:   return m ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: return m ? TS_DR_EX2   : TS_DR_PAUSE;
            TS_DR_EX2:   return m ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   return m ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   return m ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   return m ? TS_IR_EX1   : TS_IR_SHIFT;
            TS_IR_SHIFT: return m ? TS_IR_EX1   : TS_IR_SHIFT;
            TS_IR_EX1:   return m ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: return m ? TS_IR_EX2   : TS_IR_PAUSE;
            TS_IR_EX2:   return m ? TS_IR_UPD   : TS_IR_SHIFT;
            default:     return m ? TS_DR_SEL   : TS_IDLE;
        endcase
    endfunction

    function automatic route_e pick_route(logic [IR_W-1:0] ir, logic [SEL_W-1:0] ch);
        if (ir == OP_ITRPICK) return RT_ITR;
        if (ir == OP_CHSEL)   return RT_SEL;
        if (ir == OP_INTEST || ir == OP_EXTEST) begin
            if (ch == CH_ITR_NUM)  return RT_ITR;
            if (ch == CH_DTR_NUM)  return RT_DTR;
            if (ch == CH_CTRL_NUM) return RT_CTRL;
        end
        return RT_BYPASS;
    endfunction

    function automatic int route_len(route_e r, int word_w);
        case (r)
            RT_SEL:          return SEL_W;
            RT_ITR, RT_DTR:  return word_w + 1;
            RT_CTRL:         return word_w;
            default:         return 1;
        endcase
    endfunction

endpackage

// File: rtl/dbg_tap_ctrl.sv
module dbg_tap_ctrl
    import dbg_inject_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tms,
    input  logic            tdi,
    output tap_state_e      st,
    output tap_state_e      st_nxt,
    output logic [IR_W-1:0] ir,
    output logic [IR_W-1:0] ir_sh,
    output logic [IR_W-1:0] ir_eff
);

    always_comb begin
        st_nxt = tap_step(st, tms);
        ir_eff = (st == TS_IR_UPD) ? ir_sh : ir;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= TS_RESET;
        else     st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || st == TS_RESET) begin
            ir    <= OP_BYPASS;
            ir_sh <= '0;
        end else begin
            case (st)
                TS_IR_CAP:   ir_sh <= {{(IR_W-2){1'b0}}, 2'b01};
                TS_IR_SHIFT: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                TS_IR_UPD:   ir    <= ir_sh;
                default: ;
            endcase
        end
    end

    // R1: the test-logic-reset state always leaves bypass in the IR
    p_ir_bypass_r1: assert property (@(posedge clk) disable iff (rst)
        st == TS_RESET |=> ir == OP_BYPASS);

    // R2: the instruction only changes when Update-IR is passed
    p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (st != TS_IR_UPD && st != TS_RESET) |=> $stable(ir));

endmodule

// File: rtl/dbg_dr_path.sv
module dbg_dr_path
    import dbg_inject_pkg::*;
#(
    parameter int DW = 33
) (
    input  logic          clk,
    input  logic          rst,
    input  tap_state_e    st,
    input  logic          tdi,
    input  route_e        rt,
    input  logic [DW-1:0] cap_val,
    output logic [DW-1:0] dr_sh
);

    int            len;
    logic [DW-1:0] shifted;

    always_comb begin
        len     = route_len(rt, DW - 1);
        shifted = dr_sh >> 1;
        for (int i = 0; i < DW; i++) begin
            if (i == len - 1) shifted[i] = tdi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dr_sh <= '0;
        end else if (st == TS_DR_CAP) begin
            dr_sh <= cap_val;
        end else if (st == TS_DR_SHIFT) begin
            dr_sh <= shifted;
        end
    end

    // R2: a partly shifted chain value is held across Pause-DR until update
    p_pause_hold_r2: assert property (@(posedge clk) disable iff (rst)
        st == TS_DR_PAUSE |=> $stable(dr_sh));

endmodule

// File: rtl/dbg_exec_unit.sv
module dbg_exec_unit
    import dbg_inject_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  tap_state_e        st,
    input  tap_state_e        st_nxt,
    input  logic [IR_W-1:0]   ir,
    input  logic [IR_W-1:0]   ir_eff,
    input  route_e            rt,
    input  logic [DATA_W:0]   dr_sh,
    input  logic              core_done,
    input  logic              core_halted,
    input  logic [DATA_W-1:0] core_dtr_data,
    input  logic              core_dtr_valid,
    output logic [DATA_W:0]   cap_val,
    output logic [SEL_W-1:0]  chain_sel,
    output logic [DATA_W-1:0] itr_op,
    output logic              issue,
    output logic              wr_strobe,
    output logic [DATA_W-1:0] wr_data,
    output logic              take
);

    logic ready, itr_en;
    logic upd_edge, enter_idle, armed, fire;

    always_comb begin
        upd_edge   = (st == TS_DR_UPD);
        enter_idle = (st != TS_IDLE) && (st_nxt == TS_IDLE);
        armed      = (ir_eff == OP_ITRPICK) ||
                     ((ir_eff == OP_INTEST || ir_eff == OP_EXTEST) &&
                      (chain_sel == CH_ITR_NUM || chain_sel == CH_DTR_NUM));
        fire       = enter_idle && ready && itr_en && core_halted && armed;
    end

    always_comb begin
        case (rt)
            RT_SEL:  cap_val = {{(DATA_W+1-SEL_W){1'b0}}, chain_sel};
            RT_ITR:  cap_val = {{DATA_W{1'b0}}, ready};
            RT_DTR:  cap_val = {core_dtr_data, core_dtr_valid};
            RT_CTRL: cap_val = {{(DATA_W-2){1'b0}}, ready, core_halted, itr_en};
            default: cap_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_sel <= '0;
            itr_op    <= '0;
            ready     <= 1'b1;
            itr_en    <= 1'b0;
            issue     <= 1'b0;
            wr_strobe <= 1'b0;
            wr_data   <= '0;
            take      <= 1'b0;
        end else begin
            issue     <= fire;
            wr_strobe <= 1'b0;
            take      <= 1'b0;
            if (fire)           ready <= 1'b0;
            else if (core_done) ready <= 1'b1;
            if (upd_edge) begin
                case (rt)
                    RT_SEL:  chain_sel <= dr_sh[SEL_W-1:0];
                    RT_ITR:  if (ready) itr_op <= dr_sh[DATA_W:1];
                    RT_DTR:  if (ir == OP_EXTEST) begin
                                 wr_strobe <= 1'b1;
                                 wr_data   <= dr_sh[DATA_W:1];
                             end
                    RT_CTRL: if (ir == OP_EXTEST) itr_en <= dr_sh[0];
                    default: ;
                endcase
            end
            if (st == TS_DR_CAP && rt == RT_DTR && ir == OP_INTEST && core_dtr_valid)
                take <= 1'b1;
        end
    end

    // R13: an issued opcode leaves Ready low
    p_issue_clears_ready_r13: assert property (@(posedge clk) disable iff (rst)
        issue |-> !ready);

    // R6: an issue needs execution enabled and a halted core one cycle earlier
    p_issue_gate_r6: assert property (@(posedge clk) disable iff (rst)
        issue |-> $past(itr_en && core_halted));

    // R7: dwelling in Idle never repeats the strobe
    p_single_issue_r7: assert property (@(posedge clk) disable iff (rst)
        (st == TS_IDLE && $past(st) == TS_IDLE) |-> !issue);

    // R5: instruction-transfer update while not ready keeps the old opcode
    p_drop_write_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_edge && rt == RT_ITR && !ready) |=> $stable(itr_op));

    // R11: a write strobe only follows Update-DR
    p_wr_after_update_r11: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> $past(st) == TS_DR_UPD);

    // R3: the stored chain number moves only on an update of the select chain
    p_chain_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(upd_edge && rt == RT_SEL) |=> $stable(chain_sel));

endmodule

// File: rtl/dbg_inject_port.sv
module dbg_inject_port
    import dbg_inject_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    input  logic              core_halted,
    input  logic              core_done,
    input  logic [DATA_W-1:0] core_dtr_data,
    input  logic              core_dtr_valid,
    output logic              core_issue,
    output logic [DATA_W-1:0] core_opcode,
    output logic              core_dtr_take,
    output logic              dtr_wr_strobe,
    output logic [DATA_W-1:0] dtr_wr_data
);

    localparam int DW = DATA_W + 1;

    tap_state_e       st, st_nxt;
    logic [IR_W-1:0]  ir, ir_sh, ir_eff;
    logic [SEL_W-1:0] chain_sel;
    route_e           rt;
    logic [DW-1:0]    dr_sh, cap_val;

    always_comb rt = pick_route(ir, chain_sel);

    always_comb begin
        case (st)
            TS_IR_SHIFT: tdo = ir_sh[0];
            TS_DR_SHIFT: tdo = dr_sh[0];
            default:     tdo = 1'b0;
        endcase
    end

    dbg_tap_ctrl u_tap (
        .clk(clk), .rst(rst), .tms(tms), .tdi(tdi),
        .st(st), .st_nxt(st_nxt), .ir(ir), .ir_sh(ir_sh), .ir_eff(ir_eff)
    );

    dbg_dr_path #(.DW(DW)) u_dr (
        .clk(clk), .rst(rst), .st(st), .tdi(tdi), .rt(rt),
        .cap_val(cap_val), .dr_sh(dr_sh)
    );

    dbg_exec_unit #(.DATA_W(DATA_W)) u_exec (
        .clk(clk), .rst(rst), .st(st), .st_nxt(st_nxt), .ir(ir), .ir_eff(ir_eff),
        .rt(rt), .dr_sh(dr_sh), .core_done(core_done), .core_halted(core_halted),
        .core_dtr_data(core_dtr_data), .core_dtr_valid(core_dtr_valid),
        .cap_val(cap_val), .chain_sel(chain_sel), .itr_op(core_opcode),
        .issue(core_issue), .wr_strobe(dtr_wr_strobe), .wr_data(dtr_wr_data),
        .take(core_dtr_take)
    );

endmodule

// File: tb/dbg_inject_port_tb.sv
`timescale 1ns/1ps
module dbg_inject_port_tb;

    localparam int W = 32;

    logic clk = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0, tdo;
    logic core_halted = 1'b1, core_done = 1'b0, core_dtr_valid = 1'b0;
    logic [W-1:0] core_dtr_data = '0;
    logic core_issue, core_dtr_take, dtr_wr_strobe;
    logic [W-1:0] core_opcode, dtr_wr_data;

    always #2 clk = ~clk;

    dbg_inject_port #(.DATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo),
        .core_halted(core_halted), .core_done(core_done),
        .core_dtr_data(core_dtr_data), .core_dtr_valid(core_dtr_valid),
        .core_issue(core_issue), .core_opcode(core_opcode),
        .core_dtr_take(core_dtr_take), .dtr_wr_strobe(dtr_wr_strobe),
        .dtr_wr_data(dtr_wr_data)
    );

    int vectors = 0, miscompares = 0;
    int issue_cnt = 0, take_cnt = 0, wr_cnt = 0, exp_issue = 0;
    int pend = 0, done_req = 0, done_seen = 0;
    bit auto_done = 1'b0;
    logic [W-1:0] last_op = '0, last_wr = '0;

    // core model: counts strobes and returns done pulses
    always @(negedge clk) begin
        core_done = 1'b0;
        if (core_issue) begin
            issue_cnt++;
            last_op = core_opcode;
            if (auto_done) pend = 3;
        end
        if (core_dtr_take) take_cnt++;
        if (dtr_wr_strobe) begin wr_cnt++; last_wr = dtr_wr_data; end
        if (pend > 0) begin pend--; if (pend == 0) core_done = 1'b1; end
        if (done_req != done_seen) begin done_seen = done_req; core_done = 1'b1; end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tck(input logic m, input logic d, output logic o);
        @(negedge clk);
        tms = m; tdi = d;
        #1 o = tdo;
    endtask

    task automatic step(input logic m);
        logic o;
        tck(m, 1'b0, o);
    endtask

    task automatic idle_for(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    task automatic pulse_done();
        done_req++;
        idle_for(2);
    endtask

    task automatic load_ir(input logic [4:0] code);
        logic o;
        step(1'b1); step(1'b1); step(1'b0); step(1'b0);
        for (int i = 0; i < 5; i++) tck(i == 4, code[i], o);
        step(1'b1); step(1'b0);
    endtask

    task automatic scan_dr(input logic [32:0] din, input int n, output logic [32:0] dout);
        logic o;
        dout = '0;
        step(1'b1); step(1'b0); step(1'b0);
        for (int i = 0; i < n; i++) begin
            tck(i == n - 1, din[i], o);
            dout[i] = o;
        end
        step(1'b1); step(1'b0);
    endtask

    function automatic logic [32:0] bypass_expect(input logic [32:0] din, input int n);
        logic [32:0] r = '0;
        for (int i = 1; i < n; i++) r[i] = din[i-1];
        return r;
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [32:0] d;
        logic [W-1:0] op_x, op_y, wd, cd;
        void'($urandom(32'd7321));
        op_x = 32'hE1A0_0000; op_y = 32'hDEAD_BEEF;
        wd = 32'h1234_5678; cd = 32'hCAFE_F00D;

        repeat (3) step(1'b1);
        @(negedge clk) rst = 1'b0;
        step(1'b0);
        idle_for(2);
        check("R1 no issue after reset", core_issue, 0);
        check("R1 no write after reset", dtr_wr_strobe, 0);

        scan_dr(33'b1011, 4, d);
        check("R1 bypass after reset", d, bypass_expect(33'b1011, 4));
        load_ir(5'h15);
        scan_dr(33'b0110, 4, d);
        check("R12 unknown IR bypass", d, bypass_expect(33'b0110, 4));

        load_ir(5'h02);
        scan_dr(33'd1, 5, d);
        check("R2 chain number reads 0 after reset", d[4:0], 0);
        load_ir(5'h00);
        scan_dr(33'd1, 32, d);
        load_ir(5'h0C);
        scan_dr(33'd0, 32, d);
        check("R9 control chain ready/halted/enable", d[2:0], 3'b111);
        idle_for(2);
        check("R8 control chain never issues", issue_cnt, 0);

        load_ir(5'h02);
        scan_dr(33'd5, 5, d);
        check("R2 previous chain number captured", d[4:0], 1);

        load_ir(5'h1D);
        idle_for(2);
        exp_issue = 1;
        check("R6 shortcut load arms issue", issue_cnt, exp_issue);
        pulse_done();
        scan_dr({op_x, 1'b0}, 33, d);
        check("R4 ready bit returned", d[0], 1);
        check("R4 opcode bits read as zero", d[32:1], 0);
        idle_for(2);
        exp_issue++;
        check("R6 issue on idle entry", issue_cnt, exp_issue);
        check("R6 issued opcode", last_op, op_x);
        idle_for(8);
        check("R7 long idle issues once", issue_cnt, exp_issue);

        scan_dr({op_y, 1'b0}, 33, d);
        check("R13 ready low after issue", d[0], 0);
        idle_for(2);
        check("R6 no issue while not ready", issue_cnt, exp_issue);
        pulse_done();
        load_ir(5'h1D);
        idle_for(2);
        exp_issue++;
        check("R13 ready restored by done", issue_cnt, exp_issue);
        check("R5 dropped write kept old opcode", last_op, op_x);
        pulse_done();

        load_ir(5'h02);
        scan_dr(33'd5, 5, d);
        check("R3 shortcut left chain number", d[4:0], 5);

        auto_done = 1'b1;
        load_ir(5'h00);
        idle_for(4);
        exp_issue++;
        scan_dr({wd, 1'b0}, 33, d);
        idle_for(4);
        exp_issue++;
        check("R11 write strobe count", wr_cnt, 1);
        check("R11 write data", last_wr, wd);
        check("R6 chain 5 under write arms", issue_cnt, exp_issue);

        core_dtr_data = cd; core_dtr_valid = 1'b1;
        load_ir(5'h0C);
        idle_for(4);
        exp_issue++;
        scan_dr(33'd0, 33, d);
        idle_for(4);
        exp_issue++;
        core_dtr_valid = 1'b0;
        check("R10 data chain capture", d, {cd, 1'b1});
        check("R10 take pulse", take_cnt, 1);
        check("R11 no write under read", wr_cnt, 1);
        check("R6 chain 5 under read arms", issue_cnt, exp_issue);

        load_ir(5'h02);
        scan_dr(33'd2, 5, d);
        load_ir(5'h0C);
        idle_for(4);
        scan_dr(33'b011, 3, d);
        check("R8 unassigned chain acts as bypass", d, bypass_expect(33'b011, 3));
        idle_for(4);
        check("R8 unassigned chain never issues", issue_cnt, exp_issue);

        load_ir(5'h02); scan_dr(33'd1, 5, d);
        load_ir(5'h00); scan_dr(33'd0, 32, d);
        load_ir(5'h0C); scan_dr(33'd0, 32, d);
        check("R9 enable bit written to 0", d[2:0], 3'b110);
        load_ir(5'h02); scan_dr(33'd4, 5, d);
        load_ir(5'h0C);
        idle_for(4);
        check("R6 disabled execution blocks issue", issue_cnt, exp_issue);

        load_ir(5'h02); scan_dr(33'd1, 5, d);
        load_ir(5'h00); scan_dr(33'd1, 32, d);
        load_ir(5'h1D);
        idle_for(4);
        exp_issue++;
        check("R6 re-enabled execution issues", issue_cnt, exp_issue);

        for (int k = 0; k < 10; k++) begin
            logic [W-1:0] op;
            int gap;
            op  = $urandom;
            gap = $urandom_range(1, 6);
            scan_dr({op, 1'b0}, 33, d);
            idle_for(gap + 3);
            exp_issue++;
            check("R4 ready seen before random write", d[0], 1);
            check("R6 random opcode issued", last_op, op);
            check("R7 one issue per idle entry", issue_cnt, exp_issue);
        end

        finish_run();
    end

endmodule